// File: doc/BRIEF.md
# Input Glitch Filter with Selectable Sampling

This block cleans up slow external inputs, such as timer capture and trigger pins, before downstream logic reacts to their edges. Each channel first passes its pin through a two-flop synchroniser on the operating clock. The synchronised value is then sampled on a shared strobe into a three-deep shift register. The filtered level changes only when all three stored samples agree. A pulse shorter than three sample periods is therefore treated as noise.

The sample strobe can run at the operating clock rate, at one eighth of it, at one thirty-second of it, or at the timer count-source rate. The count source has its own select. It can be a prescaler tap of the operating clock or the rising edge of an external timer clock, which is synchronised first. A per-channel enable picks either the filtered level or the plain synchronised level. An edge detector then turns the chosen level into single-cycle rise and fall pulses. Four channels share one strobe generator.

Top module: `glitch_filter_top`

## Requirements
- R1: With the filter enabled, a channel's level output changes only after three consecutive strobe samples of the synchronised pin all hold the new value.
- R2: With the filter enabled, a pin pulse lasting one or two strobe periods never reaches the level output and produces no rise or fall pulse.
- R3: With the filter enabled and a strobe period of P clock cycles, a pin change held steady reaches the level output within 3*P+3 clock cycles. This is at most five strobe periods whenever P is at least 2.
- R4: The sample select `smp_sel` sets the strobe period: 00 gives every cycle, 01 gives every 8 cycles, 10 gives every 32 cycles, and 11 uses the count-source strobe.
- R5: The count-source select `src_sel` gives the following periods: 000 is 1 cycle, 001 is 2, 010 is 4, 011 is 8 and 100 is 32. Code 101 gives one strobe per rising edge of `ext_tclk`. Codes 110 and 111 behave like 000.
- R6: With `filt_en` low for a channel, its level output follows the pin exactly two clock cycles later and ignores the sampling.
- R7: `rise_out` is high for exactly one cycle when a channel's level output goes from 0 to 1. `fall_out` is high for exactly one cycle when it goes from 1 to 0.
- R8: During reset and in the first cycle after reset, all level outputs are 0 and no rise or fall pulse is present.
- R9: Channels are independent. A rise on one channel and a fall on another can appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 3 | Count-source select (R5 encoding) |
| smp_sel | input | 2 | Sample-strobe select (R4 encoding) |
| ext_tclk | input | 1 | External timer clock, asynchronous |
| filt_en | input | NUM_CH | Per-channel filter enable (1 = filtered, 0 = bypass) |
| pin_in | input | NUM_CH | Raw asynchronous channel inputs |
| level_out | output | NUM_CH | Selected level per channel |
| rise_out | output | NUM_CH | One-cycle rising-edge pulse per channel |
| fall_out | output | NUM_CH | One-cycle falling-edge pulse per channel |

## Verification
Edge detection on one channel can coincide with edge detection of the opposite polarity on another channel. The bench provokes this by placing two channels in bypass and moving one pin up and the other pin down on the same falling clock edge. It then expects `rise_out` on one channel and `fall_out` on the other in the same cycle, exactly two cycles later. In filtered mode, the strobe landing in the same cycle as a pin transition is covered by sweeping every select code. Latency is bounded by 3*P+3, and pulses of P and 2*P cycles must stay invisible.

// File: rtl/gf_pkg.sv
package gf_pkg;
    localparam int PRE_W = 5;   // prescaler width, largest tap is 2**PRE_W
    localparam int SMP_N = 3;   // agreeing samples needed

    typedef enum logic [1:0] {
        SMP_DIV1  = 2'b00,
        SMP_DIV8  = 2'b01,
        SMP_DIV32 = 2'b10,
        SMP_CSRC  = 2'b11
    } smp_sel_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [1:0]       ext_sync;
        logic             ext_prev;
    } stb_state_t;

    typedef struct packed {
        logic [1:0]       sync;
        logic [SMP_N-1:0] smp;
        logic             filt;
        logic             prev;
    } chan_state_t;
endpackage

// File: rtl/gf_strobe_gen.sv
module gf_strobe_gen
    import gf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src_sel,
    input  logic [1:0] smp_sel,
    input  logic       ext_tclk,
    output logic       strobe
);
    stb_state_t st_d, st_q;
    logic [PRE_W:0] tap;   // tap[k] fires once every 2**k cycles
    logic ext_stb;
    logic csrc_stb;

    assign tap[0] = 1'b1;
    for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
        assign tap[k] = &st_q.pre[k-1:0];
    end

    always_comb begin
        st_d          = st_q;
        st_d.pre      = st_q.pre + 1'b1;
        st_d.ext_sync = {st_q.ext_sync[0], ext_tclk};
        st_d.ext_prev = st_q.ext_sync[1];
        ext_stb       = st_q.ext_sync[1] & ~st_q.ext_prev;
        case (src_sel)
            3'b001:  csrc_stb = tap[1];
            3'b010:  csrc_stb = tap[2];
            3'b011:  csrc_stb = tap[3];
            3'b100:  csrc_stb = tap[5];
            3'b101:  csrc_stb = ext_stb;
            default: csrc_stb = tap[0];
        endcase
        case (smp_sel_e'(smp_sel))
            SMP_DIV8:  strobe = tap[3];
            SMP_DIV32: strobe = tap[5];
            SMP_CSRC:  strobe = csrc_stb;
            default:   strobe = tap[0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    ext_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_stb |=> !ext_stb);

    // R4
    div8_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap[3] |=> !tap[3]);
endmodule

// File: rtl/gf_channel.sv
module gf_channel
    import gf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic pin,
    input  logic filt_en,
    output logic level,
    output logic rise,
    output logic fall
);
    chan_state_t ch_d, ch_q;
    logic sel;

    always_comb begin
        ch_d      = ch_q;
        ch_d.sync = {ch_q.sync[0], pin};
        if (strobe)
            ch_d.smp = {ch_q.smp[SMP_N-2:0], ch_q.sync[1]};
        if (&ch_q.smp)
            ch_d.filt = 1'b1;
        else if (~|ch_q.smp)
            ch_d.filt = 1'b0;
        sel       = filt_en ? ch_q.filt : ch_q.sync[1];
        ch_d.prev = sel;
        level     = sel;
        rise      = sel & ~ch_q.prev;
        fall      = ~sel & ch_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    // R1
    filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.filt != $past(ch_q.filt)) |-> ($past(ch_q.smp) == {SMP_N{ch_q.filt}}));

    // R1
    smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(ch_q.smp));

    // R7
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rise && !fall));
endmodule

// File: rtl/glitch_filter_top.sv
module glitch_filter_top #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        src_sel,
    input  logic [1:0]        smp_sel,
    input  logic              ext_tclk,
    input  logic [NUM_CH-1:0] filt_en,
    input  logic [NUM_CH-1:0] pin_in,
    output logic [NUM_CH-1:0] level_out,
    output logic [NUM_CH-1:0] rise_out,
    output logic [NUM_CH-1:0] fall_out
);
    logic strobe;

    gf_strobe_gen u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .smp_sel  (smp_sel),
        .ext_tclk (ext_tclk),
        .strobe   (strobe)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gf_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe  (strobe),
            .pin     (pin_in[c]),
            .filt_en (filt_en[c]),
            .level   (level_out[c]),
            .rise    (rise_out[c]),
            .fall    (fall_out[c])
        );
    end

    // R7
    no_dual_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_out & fall_out) == '0);
endmodule

// File: tb/sim_glitch_filter_top.sv
module sim_glitch_filter_top;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] src_sel = 3'b000;
    logic [1:0] smp_sel = 2'b00;
    logic ext_tclk = 1'b0;
    logic [NCH-1:0] filt_en = '1;
    logic [NCH-1:0] pin_in = '0;
    logic [NCH-1:0] level_out, rise_out, fall_out;

    int n_tests = 0;
    int n_fail = 0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    glitch_filter_top #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .smp_sel(smp_sel),
        .ext_tclk(ext_tclk), .filt_en(filt_en), .pin_in(pin_in),
        .level_out(level_out), .rise_out(rise_out), .fall_out(fall_out)
    );

    // external timer clock: period 10 operating cycles
    initial forever begin
        repeat (5) @(negedge clk);
        ext_tclk = ~ext_tclk;
    end

    always @(negedge clk) begin
        if (rise_out[0]) rise_cnt++;
        if (fall_out[0]) fall_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input logic [1:0] s, input logic [2:0] c);
        case (s)
            2'b01: return 8;
            2'b10: return 32;
            2'b11: case (c)
                3'b001: return 2;
                3'b010: return 4;
                3'b011: return 8;
                3'b100: return 32;
                3'b101: return 10;
                default: return 1;
            endcase
            default: return 1;
        endcase
    endfunction

    // drive ch0 to tgt, count posedges until the level follows
    task automatic step(input logic tgt, input int lim, output int n);
        pin_in[0] = tgt;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (level_out[0] !== tgt && n < lim + 8);
    endtask

    task automatic run_cfg(input logic [1:0] s, input logic [2:0] c);
        int p, n, r0, f0;
        bit held;
        p = period_of(s, c);
        smp_sel = s;
        src_sel = c;
        filt_en = '1;
        pin_in = '0;
        repeat (4 * p + 8) @(negedge clk);
        // R2: glitches of one and two strobe periods
        for (int g = 1; g <= 2; g++) begin
            r0 = rise_cnt;
            pin_in[0] = 1'b1;
            repeat (g * p) @(negedge clk);
            pin_in[0] = 1'b0;
            held = 1;
            repeat (3 * p + 8) begin
                @(negedge clk);
                if (level_out[0] !== 1'b0) held = 0;
            end
            chk(held && rise_cnt == r0, $sformatf("R2 glitch %0dP sel=%0d src=%0d", g, s, c),
                rise_cnt - r0, 0);
        end
        // R1 R3 R4 R5: step up and down within 3P+3
        r0 = rise_cnt;
        step(1'b1, 3 * p + 3, n);
        chk(n <= 3 * p + 3, $sformatf("R3 R4 R5 rise latency sel=%0d src=%0d", s, c), n, 3 * p + 3);
        chk(n >= 3, $sformatf("R1 rise too early sel=%0d src=%0d", s, c), n, 3);
        repeat (4 * p + 8) @(negedge clk);
        chk(rise_cnt == r0 + 1, "R7 single rise pulse filtered", rise_cnt - r0, 1);
        f0 = fall_cnt;
        step(1'b0, 3 * p + 3, n);
        chk(n <= 3 * p + 3, $sformatf("R3 R4 R5 fall latency sel=%0d src=%0d", s, c), n, 3 * p + 3);
        repeat (4 * p + 8) @(negedge clk);
        chk(fall_cnt == f0 + 1, "R7 single fall pulse filtered", fall_cnt - f0, 1);
        // R6: bypass
        filt_en[0] = 1'b0;
        repeat (4) @(negedge clk);
        r0 = rise_cnt;
        step(1'b1, 2, n);
        chk(n == 2, $sformatf("R6 bypass latency sel=%0d src=%0d", s, c), n, 2);
        repeat (4) @(negedge clk);
        chk(rise_cnt == r0 + 1, "R7 single rise pulse bypass", rise_cnt - r0, 1);
        pin_in[0] = 1'b0;
        repeat (6) @(negedge clk);
        filt_en[0] = 1'b1;
        repeat (4 * p + 8) @(negedge clk);
    endtask

    initial begin
        pin_in = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(level_out == '0 && rise_out == '0 && fall_out == '0, "R8 in reset", int'(level_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(level_out == '0 && rise_out == '0 && fall_out == '0, "R8 first cycle", int'(rise_out | fall_out), 0);

        for (int s = 0; s < 3; s++) run_cfg(2'(s), 3'b000);
        for (int c = 0; c < 8; c++) run_cfg(2'b11, 3'(c));

        // R9: opposite edges on two channels in one cycle
        filt_en = 4'b1001;
        pin_in = 4'b0010;
        repeat (6) @(negedge clk);
        chk(level_out == 4'b0010, "R9 setup levels", int'(level_out), 2);
        pin_in = 4'b0100;
        repeat (2) @(negedge clk);
        chk(rise_out == 4'b0100 && fall_out == 4'b0010, "R9 same-cycle rise/fall",
            int'({rise_out, fall_out}), 8'h42);
        @(negedge clk);
        chk(rise_out == '0 && fall_out == '0, "R7 pulses last one cycle",
            int'({rise_out, fall_out}), 0);
        chk(level_out[0] == 1'b0 && level_out[3] == 1'b0, "R9 other channels undisturbed",
            int'(level_out), 4);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule